// File: doc/BRIEF.md
# Up/Down Address Counter with Wrap Error

This block is a 16-bit address counter meant for one memory port. Its value drives a dedicated address output at all times, so no shared address bus is needed. The counter can be loaded from the shared data bus. It can count up or down, and it can place its value back onto the data bus so that another device can copy it in the same cycle.

Every change to the count is qualified by an active-low card write enable, which acts as a clock gate. When several actions are requested in the same cycle, load wins over increment, and increment wins over decrement. Raising increment and decrement together, without load, leaves the count unchanged.

A sticky error flag records any wrap of the count in either direction. A wrap is a step up from all-ones or a step down from zero. The flag stays set until a synchronous reset or a dedicated clear input. A load never sets the flag, whatever value is loaded.

Top module: `addr_counter_card`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) makes the count 0x0000 and the error flag 0 after that edge, whatever the other inputs are.
- R2: addr_out equals the current count at all times.
- R3: With we_n low and load high at a rising edge, the count takes the value on data_bus, regardless of inc and dec.
- R4: With we_n low and load low, inc high and dec low adds one to the count, and dec high with inc low subtracts one.
- R5: With we_n high, load, inc and dec have no effect: the count and the error flag are unchanged, and no wrap is recorded.
- R6: With we_n low, load low and both inc and dec high, the count holds and no wrap is recorded.
- R7: An enabled increment from 0xFFFF gives 0x0000, and an enabled decrement from 0x0000 gives 0xFFFF. Each of these sets err to 1 after that edge.
- R8: A load never sets err, even when the loaded value is 0x0000 or 0xFFFF. Once set, err stays 1 across later loads and counts until it is cleared or reset.
- R9: clr_err high at a rising edge clears err, whatever we_n is. If a wrap happens at that same edge, err is 1 afterwards.
- R10: With oe_n low the count is driven onto data_bus. With oe_n high the block does not drive data_bus, so another device can drive any value onto it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| we_n | input | 1 | Card write enable, active low; gates load and count |
| oe_n | input | 1 | Data bus output enable, active low |
| load | input | 1 | Load count from data bus, active high |
| inc | input | 1 | Count up request, active high |
| dec | input | 1 | Count down request, active high |
| clr_err | input | 1 | Clear the wrap error flag, active high |
| data_bus | inout | 16 | Shared data bus, read on load and driven when oe_n is low |
| addr_out | output | 16 | Dedicated address output, always the count |
| err | output | 1 | Sticky wrap error flag |

## Verification
The bench goes after both wrap boundaries and the priority rules. A design that flagged only upward wraps would leave err low after 0x0000 counts down. A design that tested the stored value instead of the action taken would raise err on a load of 0xFFFF or 0x0000. The bench also checks that wraps requested while the card is disabled, or through a cancelling increment and decrement, record nothing; a gate applied only to the count and not to the wrap detector would fail there. A clear that coincides with a wrap must leave err set, so a design that gives clear the higher priority loses the error. Finally, a reset in mid-run must zero both the count and a set flag.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_UP   = 2'd2,
    ACT_DOWN = 2'd3
  } ctr_act_e;

endpackage

// File: rtl/addr_ctr_ctrl.sv
module addr_ctr_ctrl
  import addr_ctr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we_n,
  input  logic     load,
  input  logic     inc,
  input  logic     dec,
  output ctr_act_e act
);

  logic card_en;

  assign card_en = ~we_n;

  always_comb begin
    act = ACT_HOLD;
    if (card_en) begin
      if (load)             act = ACT_LOAD;
      else if (inc && !dec) act = ACT_UP;
      else if (dec && !inc) act = ACT_DOWN;
      else                  act = ACT_HOLD;
    end
  end

  // R5: a disabled card never acts
  p_gated_r5: assert property (@(posedge clk) disable iff (rst)
    we_n |-> (act == ACT_HOLD));

  // R6: cancelling requests hold
  p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && inc && dec) |-> (act == ACT_HOLD));

  // R3: load beats counting
  p_loadwin_r3: assert property (@(posedge clk) disable iff (rst)
    (!we_n && load) |-> (act == ACT_LOAD));

endmodule

// File: rtl/addr_ctr_core.sv
module addr_ctr_core
  import addr_ctr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctr_act_e         act,
  input  logic [WIDTH-1:0] din,
  input  logic             clr_err,
  output logic [WIDTH-1:0] count,
  output logic             err,
  output logic             wrap_evt
);

  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] TOP  = '1;

  function automatic logic [WIDTH-1:0] next_value(ctr_act_e a,
                                                  logic [WIDTH-1:0] cur,
                                                  logic [WIDTH-1:0] d);
    case (a)
      ACT_LOAD: return d;
      ACT_UP:   return cur + ONE;
      ACT_DOWN: return cur - ONE;
      default:  return cur;
    endcase
  endfunction

  function automatic logic wraps(ctr_act_e a, logic [WIDTH-1:0] cur);
    return ((a == ACT_UP) && (cur == TOP)) || ((a == ACT_DOWN) && (cur == ZERO));
  endfunction

  assign wrap_evt = wraps(act, count);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= ZERO;
      err   <= 1'b0;
    end else begin
      count <= next_value(act, count, din);
      if (wrap_evt)     err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end

  // R1: reset result
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == ZERO) && !err);

  // R3: loaded value lands
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD) |=> (count == $past(din)));

  // R4: up step
  p_up_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_UP) |=> (count == $past(count) + ONE));

  // R4: down step
  p_down_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_DOWN) |=> (count == $past(count) - ONE));

  // R6: hold keeps value
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> $stable(count));

  // R7: a wrap raises the flag
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> err);

  // R8: flag sticky without clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err && !clr_err) |=> err);

  // R8: no wrap, no new flag
  p_norise_r8: assert property (@(posedge clk) disable iff (rst)
    (!err && !wrap_evt) |=> !err);

  // R9: clear drops the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !wrap_evt) |=> !err);

endmodule

// File: rtl/addr_ctr_bus.sv
module addr_ctr_bus #(
  parameter int WIDTH = 16
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] bus_in,
  inout  wire  [WIDTH-1:0] data_bus
);

  assign data_bus = oe_n ? {WIDTH{1'bz}} : count;
  assign bus_in   = data_bus;

endmodule

// File: rtl/addr_counter_card.sv
module addr_counter_card
  import addr_ctr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             load,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr_err,
  inout  wire  [WIDTH-1:0] data_bus,
  output logic [WIDTH-1:0] addr_out,
  output logic             err
);

  ctr_act_e         act;
  logic [WIDTH-1:0] bus_in;
  logic [WIDTH-1:0] count;
  logic             wrap_evt;

  addr_ctr_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .we_n (we_n),
    .load (load),
    .inc  (inc),
    .dec  (dec),
    .act  (act)
  );

  addr_ctr_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .din      (bus_in),
    .clr_err  (clr_err),
    .count    (count),
    .err      (err),
    .wrap_evt (wrap_evt)
  );

  addr_ctr_bus #(.WIDTH(WIDTH)) u_bus (
    .oe_n     (oe_n),
    .count    (count),
    .bus_in   (bus_in),
    .data_bus (data_bus)
  );

  assign addr_out = count;

  // R5: a disabled card records no wrap
  p_nowrap_r5: assert property (@(posedge clk) disable iff (rst)
    we_n |-> !wrap_evt);

endmodule

// File: tb/addr_counter_card_test.sv
module addr_counter_card_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        load = 1'b0;
  logic        inc = 1'b0;
  logic        dec = 1'b0;
  logic        clr_err = 1'b0;
  logic        bus_en = 1'b1;
  logic [15:0] bus_drv = 16'h0000;
  wire  [15:0] data_bus;
  logic [15:0] addr_out;
  logic        err;

  int checks = 0;
  int fails  = 0;

  assign data_bus = bus_en ? bus_drv : 16'hzzzz;

  addr_counter_card uut (
    .clk      (clk),
    .rst      (rst),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .load     (load),
    .inc      (inc),
    .dec      (dec),
    .clr_err  (clr_err),
    .data_bus (data_bus),
    .addr_out (addr_out),
    .err      (err)
  );

  always #5 clk = ~clk;

  // fields: we_n load inc dec clr din exp_cnt exp_err req
  typedef struct packed {
    logic        we_n;
    logic        load;
    logic        inc;
    logic        dec;
    logic        clr;
    logic [15:0] din;
    logic [15:0] exp_cnt;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h1234,16'h1234,1'b0,4'd3}, // R3 load
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h1235,1'b0,4'd4}, // R4 up
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h1234,1'b0,4'd4}, // R4 down
    '{1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h1234,1'b0,4'd5}, // R5 disabled up
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h5555,16'h1234,1'b0,4'd5}, // R5 disabled load
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0000,16'h1234,1'b0,4'd6}, // R6 both
    '{1'b0,1'b1,1'b1,1'b1,1'b0,16'h00FF,16'h00FF,1'b0,4'd3}, // R3 priority
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'hFFFF,16'hFFFF,1'b0,4'd8}, // R8 load top
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,1'b1,4'd7}, // R7 up wrap
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h0010,16'h0010,1'b1,4'd8}, // R8 sticky
    '{1'b1,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0010,1'b0,4'd9}, // R9 clear
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,4'd8}, // R8 load zero
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'hFFFF,1'b1,4'd7}, // R7 down wrap
    '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h0000,16'h0000,1'b1,4'd9}, // R9 wrap beats clear
    '{1'b1,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0000,1'b0,4'd9}, // R9 clear
    '{1'b1,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h0000,1'b0,4'd5}, // R5 no disabled wrap
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0000,16'h0000,1'b0,4'd6}  // R6 no wrap
  };

  task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cycle(logic w, logic l, logic i, logic d, logic c, logic [15:0] v);
    @(negedge clk);
    we_n = w; load = l; inc = i; dec = d; clr_err = c; bus_drv = v;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    // R1 reset state
    rst = 1'b1;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hBEEF);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hBEEF);
    check16("R1", "count after reset", addr_out, 16'h0000);
    check1("R1", "err after reset", err, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[k].req);
      cycle(VECS[k].we_n, VECS[k].load, VECS[k].inc, VECS[k].dec, VECS[k].clr, VECS[k].din);
      check16(tag, $sformatf("vector %0d count", k), addr_out, VECS[k].exp_cnt);
      check1(tag, $sformatf("vector %0d err", k), err, VECS[k].exp_err);
    end
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);

    // R4 longer run up from a loaded value
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h7FFE);
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000);
    check16("R4", "three ups from 7FFE", addr_out, 16'h8001);
    check1("R4", "no err at mid carry", err, 1'b0);

    // R10 and R2: drive count onto the bus
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    @(negedge clk);
    bus_en = 1'b0;
    oe_n = 1'b0;
    #1;
    check16("R10", "bus driven with count", data_bus, 16'h8001);
    check16("R2", "addr_out equals count", addr_out, 16'h8001);
    @(negedge clk);
    oe_n = 1'b1;
    bus_en = 1'b1;
    bus_drv = 16'hA5C3;
    #1;
    check16("R10", "bus free when oe_n high", data_bus, 16'hA5C3);
    check16("R2", "addr_out unaffected by bus", addr_out, 16'h8001);

    // R1 mid-run reset with err set
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
    check1("R7", "err set before reset", err, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    we_n = 1'b0; load = 1'b1; bus_drv = 16'hABCD;
    @(posedge clk);
    #1;
    check16("R1", "count after mid reset", addr_out, 16'h0000);
    check1("R1", "err after mid reset", err, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    we_n = 1'b1; load = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule